// File: doc/BRIEF.md
# Serial Slave Conversion-Result Output Port

This block is the serial read-out side of an 18-bit converter. The analog conversion is not modelled. A parallel result word and a busy strobe stand in for it. When busy falls, the block captures the result into an output shift register. An external host then clocks the result out on a single data line. The host drives its own serial clock and uses an active-low select, and the serial clock counts only while that select is low.

The host picks two options. The first is which serial-clock edge moves the data line. The second is whether the result is coded as straight binary or as two's complement, where two's complement is made by inverting the MSB. Once all result bits have left, the register keeps shifting and passes the level on the serial input through to the data line. Several converters can therefore share one data line in a chain. If a host has started a read and has not finished it when the next result arrives, the unread word is dropped and a one-cycle error pulse is raised.

Serial clock and serial input are asynchronous to the system clock. Each passes through a two-flop synchroniser, and edges are detected on the synchronised levels. The serial clock must therefore run several times slower than the system clock.

Top module: `serial_result_port`

## Requirements
- R1: On a system-clock cycle in which `busy` was high in the previous cycle and is low now, the result word is loaded. From the following cycle `sdout` shows the word's MSB. Each launch edge after the first shifts the register left, so the word leaves MSB first. The bit shown after the n-th launch edge is result bit W-n, for n from 1 to W.
- R2: `fmt_bin` is sampled at load. When it is 1 the word is sent unchanged (straight binary). When it is 0 the MSB is inverted (two's complement). All other bits are unchanged.
- R3: With `launch_fall` = 0, the rising edge of `sclk` is the launch edge and the host samples on the falling edge. With `launch_fall` = 1, the falling edge launches and the host samples on the rising edge.
- R4: Each shifting launch edge (the second and later after a load) moves the synchronised `sdin` level into the register LSB. After launch edge W+k, for k ≥ 1, `sdout` shows the `sdin` level that was present at launch edge k+1.
- R5: `rd_err` goes high for exactly one system-clock cycle, in the cycle after a load, when between 1 and W-1 launch edges have occurred since the previous load. A read that has not started, or that has seen W or more launch edges, raises no error.
- R6: `sclk` edges that occur while `cs_n` is high are ignored. They neither shift the register nor advance the read.
- R7: `sdout_oe` is 1 exactly while `cs_n` is low. When it is 0, the data line is treated as high impedance.
- R8: After reset, `sdout` and `rd_err` are 0 and the launch-edge count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| res_data | input | W | Conversion result, straight binary |
| busy | input | 1 | Conversion in progress; its falling edge loads `res_data` |
| cs_n | input | 1 | Active-low select that gates `sclk` |
| sclk | input | 1 | Host serial clock (asynchronous) |
| sdin | input | 1 | Chain input from the next converter (asynchronous) |
| launch_fall | input | 1 | 0: rising edge launches data, 1: falling edge launches data |
| fmt_bin | input | 1 | 1: straight binary, 0: MSB inverted (two's complement) |
| sdout | output | 1 | Serial data |
| sdout_oe | output | 1 | Output enable for `sdout` |
| rd_err | output | 1 | One-cycle pulse when a partial read is overrun |

## Verification
The bench builds the block with W = 18 and two synchroniser stages. The full word length is therefore reachable, and so is the boundary at the W-th launch edge where a read counts as finished and chaining from `sdin` begins. Each `sclk` half period spans four system clocks, so an edge always clears the synchroniser before the next one. Both edge polarities and both codings are driven. Reads are cut off after 0, 5 and more than W edges to probe the error window at both of its ends.

// File: rtl/srp_pkg.sv
package srp_pkg;

    // Which serial-clock edge moves the data line
    typedef enum logic {
        LAUNCH_RISE = 1'b0,
        LAUNCH_FALL = 1'b1
    } launch_edge_e;

    // Level pair seen by the edge picker
    typedef struct packed {
        logic sclk;
        logic sdin;
    } serial_pins_t;

    // MSB coding: binary keeps it, two's complement flips it
    function automatic logic code_msb(input logic msb, input logic fmt_bin);
        return msb ^ ~fmt_bin;
    endfunction

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_async;
            for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/srp_edge.sv
module srp_edge
    import srp_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         level_s,
    input  launch_edge_e edge_sel,
    input  logic         sel_act,
    output logic         launch
);
    logic prev_q;
    logic rise, fall;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level_s;
    end

    assign rise   = level_s & ~prev_q;
    assign fall   = ~level_s & prev_q;
    assign launch = sel_act & ((edge_sel == LAUNCH_FALL) ? fall : rise);
endmodule

// File: rtl/srp_shift.sv
module srp_shift #(
    parameter int unsigned W = 18,
    localparam int unsigned CNT_W = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [W-1:0]     load_word,
    input  logic             launch,
    input  logic             sdin_s,
    output logic             sdout,
    output logic             err_pulse,
    output logic [CNT_W-1:0] bit_cnt
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);

    logic [W-1:0]     sr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;
    logic             partial;

    assign partial = (cnt_q != '0) && (cnt_q < CNT_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= load && partial;
            if (load) begin
                sr_q  <= load_word;
                cnt_q <= '0;
            end else if (launch) begin
                if (cnt_q != '0) sr_q <= {sr_q[W-2:0], sdin_s};
                if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign sdout     = sr_q[W-1];
    assign err_pulse = err_q;
    assign bit_cnt   = cnt_q;
endmodule

// File: rtl/serial_result_port.sv
module serial_result_port
    import srp_pkg::*;
#(
    parameter int unsigned W           = 18,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned CNT_W      = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] res_data,
    input  logic         busy,
    input  logic         cs_n,
    input  logic         sclk,
    input  logic         sdin,
    input  logic         launch_fall,
    input  logic         fmt_bin,
    output logic         sdout,
    output logic         sdout_oe,
    output logic         rd_err
);
    serial_pins_t     pins_s;
    logic             busy_q;
    logic             load;
    logic             launch;
    logic [W-1:0]     load_word;
    logic [CNT_W-1:0] bit_cnt;
    launch_edge_e     edge_sel;

    srp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({sclk, sdin}),
        .q_sync  (pins_s)
    );

    always_ff @(posedge clk) begin
        if (rst) busy_q <= 1'b0;
        else     busy_q <= busy;
    end

    assign load      = busy_q & ~busy;
    assign load_word = {code_msb(res_data[W-1], fmt_bin), res_data[W-2:0]};
    assign edge_sel  = launch_edge_e'(launch_fall);

    srp_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .level_s  (pins_s.sclk),
        .edge_sel (edge_sel),
        .sel_act  (~cs_n),
        .launch   (launch)
    );

    srp_shift #(.W(W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_word (load_word),
        .launch    (launch),
        .sdin_s    (pins_s.sdin),
        .sdout     (sdout),
        .err_pulse (rd_err),
        .bit_cnt   (bit_cnt)
    );

    assign sdout_oe = ~cs_n;
endmodule

// File: rtl/serial_result_port_chk.sv
module serial_result_port_chk #(
    parameter int unsigned W     = 18,
    parameter int unsigned CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [W-1:0]     res_data,
    input logic             fmt_bin,
    input logic             sdout,
    input logic             rd_err,
    input logic             load,
    input logic             launch,
    input logic [CNT_W-1:0] bit_cnt
);
    AST_ERR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rd_err |=> !rd_err);  // R5

    AST_ERR_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> $past(load));  // R5

    AST_LOAD_CODED_MSB: assert property (@(posedge clk) disable iff (rst)
        load |=> (sdout == ($past(res_data[W-1]) ^ !$past(fmt_bin))));  // R2

    AST_LOAD_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
        load |=> (bit_cnt == '0));  // R1

    AST_SDOUT_MOVES_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdout) |-> ($past(load) || $past(launch)));  // R6

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(W));  // R5
endmodule

bind serial_result_port serial_result_port_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .res_data (res_data),
    .fmt_bin  (fmt_bin),
    .sdout    (sdout),
    .rd_err   (rd_err),
    .load     (load),
    .launch   (launch),
    .bit_cnt  (bit_cnt)
);

// File: tb/serial_result_port_tb.sv
`timescale 1ns/1ps
module serial_result_port_tb;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] res_data = '0;
    logic         busy = 1'b0;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b0;
    logic         sdin = 1'b0;
    logic         launch_fall = 1'b0;
    logic         fmt_bin = 1'b1;
    logic         sdout, sdout_oe, rd_err;

    int n_checks = 0;
    int n_fail   = 0;
    int err_seen = 0;
    bit done     = 1'b0;

    typedef struct {
        logic  bitv;
        string req;
    } exp_item_t;
    exp_item_t sb_q[$];
    event sample_ev;

    always #2.5 clk = ~clk;

    serial_result_port #(.W(W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .res_data(res_data), .busy(busy), .cs_n(cs_n),
        .sclk(sclk), .sdin(sdin), .launch_fall(launch_fall), .fmt_bin(fmt_bin),
        .sdout(sdout), .sdout_oe(sdout_oe), .rd_err(rd_err)
    );

    always @(posedge clk) if (!rst && rd_err) err_seen++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(sample_ev);
            if (sb_q.size() == 0) begin
                check("scoreboard", 32'd1, 32'd0);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                check(it.req, {31'd0, sdout}, {31'd0, it.bitv});
            end
        end
    end

    function automatic logic idle_lvl();
        return launch_fall;
    endfunction

    task automatic one_edge(input logic din);
        @(negedge clk);
        sclk = idle_lvl();
        sdin = din;
        repeat (4) @(negedge clk);
        sclk = ~idle_lvl();
        repeat (4) @(negedge clk);
    endtask

    task automatic load_word(input logic [W-1:0] d);
        @(negedge clk);
        res_data = d;
        busy = 1'b1;
        repeat (3) @(negedge clk);
        busy = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Driver: n launch edges right after a load, pushing expected sdout
    task automatic read_bits(input int n, input logic [W-1:0] coded, input logic [31:0] pat);
        logic [W-1:0] model = coded;
        for (int i = 1; i <= n; i++) begin
            logic din = pat[i % 32];
            if (i >= 2) model = {model[W-2:0], din};
            one_edge(din);
            // R1 for result bits, R4 for chained sdin bits
            sb_q.push_back('{bitv: model[W-1], req: (i > W) ? "R4" : "R1"});
            -> sample_ev;
        end
        @(negedge clk);
        sclk = idle_lvl();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int e0;
        logic [W-1:0] w;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state, R7 with select inactive
        check("R8", {31'd0, sdout}, 32'd0);
        check("R8", {31'd0, rd_err}, 32'd0);
        check("R7", {31'd0, sdout_oe}, 32'd0);

        // Frame 1: rising launch, straight binary, with chaining
        cs_n = 1'b0;
        @(negedge clk);
        check("R7", {31'd0, sdout_oe}, 32'd1);
        w = 18'h2A5C3;
        load_word(w);
        check("R1", {31'd0, sdout}, {31'd0, w[W-1]});
        read_bits(W + 4, w, 32'hA5C3_96E1);
        e0 = err_seen;
        load_word(18'h0F0F0);  // full read before: no error (R5)
        check("R5", err_seen, e0);

        // Frame 2: falling launch, two's complement (R2, R3)
        cs_n = 1'b1;
        launch_fall = 1'b1;
        fmt_bin = 1'b0;
        @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        w = 18'h3FFFF;
        load_word(w);
        check("R2", {31'd0, sdout}, 32'd0);  // MSB inverted
        read_bits(W, {~w[W-1], w[W-2:0]}, 32'h0);  // R3 falling-edge launch

        w = 18'h12345;
        load_word(w);
        check("R2", {31'd0, sdout}, {31'd0, ~w[W-1]});
        // Partial read of 5 edges then new result: error (R5)
        read_bits(5, {~w[W-1], w[W-2:0]}, 32'h0);
        e0 = err_seen;
        load_word(18'h2AAAA);
        check("R5", err_seen, e0 + 1);
        check("R2", {31'd0, sdout}, 32'd0);

        // R6: edges with select high are ignored
        fmt_bin = 1'b1;
        launch_fall = 1'b0;
        w = 18'h20001;
        load_word(w);
        cs_n = 1'b1;
        @(negedge clk);
        check("R7", {31'd0, sdout_oe}, 32'd0);
        for (int k = 0; k < 6; k++) one_edge(1'b1);
        @(negedge clk);
        sclk = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        check("R6", {31'd0, sdout}, {31'd0, w[W-1]});
        e0 = err_seen;
        load_word(w);  // gated edges must not count as a started read
        check("R6", err_seen, e0);
        read_bits(W, w, 32'hFFFF_FFFF);

        // R5: read exactly W edges is complete; zero edges also no error
        e0 = err_seen;
        load_word(18'h15555);
        check("R5", err_seen, e0);
        load_word(18'h0AAAA);
        check("R5", err_seen, e0);
        check("R1", {31'd0, sdout}, 32'd0);

        repeat (10) @(negedge clk);
        check("scoreboard", sb_q.size(), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule